// File: doc/BRIEF.md
# Biased-Signed Byte Arithmetic Unit

This unit is the arithmetic engine of a small core built around a register file of bytes. Each request carries an operation code and up to three operand bytes. The unit returns one result byte, or a high/low byte pair, together with carry, zero and sign flags.

Most operations finish in one cycle. The supported operations are plain add and subtract, add and subtract on values held in offset-binary form, bitwise logic, and single-position shifts and rotates. Multiply and divide take several cycles. While they run, the unit drops its ready output.

The offset-binary operations re-centre the raw result by 128. Signed values kept with a bias of 128 therefore stay in that coding after the operation. The divide takes a 16-bit dividend split across two bytes. It hands back its quotient and remainder as a pair, so the core can write them over the same two registers that held the dividend.

Top module: `ofs_alu8`

## Requirements
- R1: Codes 0 (add) and 1 (subtract) give the low byte of A+B or A-B. Add sets carry when the unsigned sum exceeds 255. Subtract sets sign when A<B. The flag not named for an operation stays clear.
- R2: Code 2 gives A+B-128 and code 3 gives A-B+128, both modulo 256. Carry is set when the exact value exceeds 255. Sign is set when the exact value is below zero. Carry and sign are never set together.
- R3: Codes 4, 5 and 6 give A AND B, A OR B and A XOR B, with carry and sign clear.
- R4: Code 7 shifts A left and code 8 shifts A right, filling with zero. Code 9 rotates A left and code 10 rotates A right. Carry takes the bit moved out of the byte, and sign stays clear.
- R5: Zero is set when the result byte is 0. For multiply it is set when both product bytes are 0. For divide it is set when the high (quotient) byte is 0.
- R6: Code 11 forms the unsigned product A*B. The high byte appears on out_hi and the low byte on out_lo, with out_pair set and carry and sign clear.
- R7: Code 12 divides the dividend {A,C} by B, with A as the high byte. The quotient appears on out_hi, the remainder on out_lo, and out_pair is set. When A<B, carry is clear and the remainder is below B.
- R8: A divide with B not zero and A>=B has a quotient that does not fit in a byte. It returns 0xFF on out_hi, C unchanged on out_lo, and sets carry.
- R9: A divide with B=0 returns A on out_hi and C on out_lo, and sets carry.
- R10: Multiply and divide raise out_done exactly 9 cycles after the accepting edge. in_ready is low from the accepting edge until out_done rises. A request made while in_ready is low is ignored and leaves the outputs unchanged.
- R11: Codes 0 to 10 raise out_done for one cycle after the accepting edge, with out_pair clear and out_hi zero. Codes 13 to 15 are ignored.
- R12: After reset, all result bytes and flags read zero, out_done is low and in_ready is high. The outputs hold their last values until the next out_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_op | input | 4 | Operation code |
| in_a | input | 8 | Operand A / dividend high byte |
| in_b | input | 8 | Operand B / divisor |
| in_c | input | 8 | Dividend low byte |
| in_ready | output | 1 | Unit can accept a request |
| out_done | output | 1 | Result registered this cycle |
| out_hi | output | 8 | High result byte (product high or quotient) |
| out_lo | output | 8 | Low or only result byte |
| out_pair | output | 1 | Result is a two-byte pair |
| flag_c | output | 1 | Carry / overflow |
| flag_z | output | 1 | Zero |
| flag_s | output | 1 | Sign / underflow |

## Verification
A wrong iteration count, or a corrupted partial remainder or product, surfaces at the ports on the out_done cycle nine clocks after acceptance. It shows as a wrong byte pair, or as out_done and in_ready moving on the wrong cycle. Bias and flag errors in the one-cycle path show one clock after the request. A request that slips through while the unit is busy disturbs the held outputs on the very next cycle. The reference model compares every output on every clock, so each of these faults is reported within the cycle it becomes visible.

// File: rtl/ofs_alu8_pkg.sv
package ofs_alu8_pkg;
  localparam int DATA_W = 8;
  localparam int OPC_W  = 4;

  localparam logic [OPC_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADDO = 4'd2;
  localparam logic [OPC_W-1:0] OP_SUBO = 4'd3;
  localparam logic [OPC_W-1:0] OP_AND  = 4'd4;
  localparam logic [OPC_W-1:0] OP_OR   = 4'd5;
  localparam logic [OPC_W-1:0] OP_XOR  = 4'd6;
  localparam logic [OPC_W-1:0] OP_SHL  = 4'd7;
  localparam logic [OPC_W-1:0] OP_SHR  = 4'd8;
  localparam logic [OPC_W-1:0] OP_ROL  = 4'd9;
  localparam logic [OPC_W-1:0] OP_ROR  = 4'd10;
  localparam logic [OPC_W-1:0] OP_MUL  = 4'd11;
  localparam logic [OPC_W-1:0] OP_DIV  = 4'd12;

  // bias of 2^(W-1), held in W+2 bits so the sign of the exact value survives
  localparam logic [DATA_W+1:0] BIAS = {3'b001, {(DATA_W-1){1'b0}}};

  typedef struct packed {
    logic [DATA_W-1:0] hi;
    logic [DATA_W-1:0] lo;
    logic              pair;
    logic              c;
    logic              z;
    logic              s;
  } alu_res_t;

  function automatic logic op_known(logic [OPC_W-1:0] op);
    return op <= OP_DIV;
  endfunction

  function automatic logic op_multi(logic [OPC_W-1:0] op);
    return (op == OP_MUL) || (op == OP_DIV);
  endfunction

  // one-cycle arithmetic, logic and shift results
  function automatic alu_res_t single_op(logic [OPC_W-1:0] op,
                                         logic [DATA_W-1:0] a,
                                         logic [DATA_W-1:0] b);
    alu_res_t r;
    logic [DATA_W+1:0] ea, eb, raw;
    r   = '0;
    ea  = {2'b00, a};
    eb  = {2'b00, b};
    raw = '0;
    case (op)
      OP_ADD: begin
        raw  = ea + eb;
        r.lo = raw[DATA_W-1:0];
        r.c  = raw[DATA_W];
      end
      OP_SUB: begin
        raw  = ea - eb;
        r.lo = raw[DATA_W-1:0];
        r.s  = raw[DATA_W+1];
      end
      OP_ADDO: begin
        raw  = ea + eb - BIAS;
        r.lo = raw[DATA_W-1:0];
        r.s  = raw[DATA_W+1];
        r.c  = !raw[DATA_W+1] && raw[DATA_W];
      end
      OP_SUBO: begin
        raw  = ea - eb + BIAS;
        r.lo = raw[DATA_W-1:0];
        r.s  = raw[DATA_W+1];
        r.c  = !raw[DATA_W+1] && raw[DATA_W];
      end
      OP_AND: r.lo = a & b;
      OP_OR:  r.lo = a | b;
      OP_XOR: r.lo = a ^ b;
      OP_SHL: begin r.lo = {a[DATA_W-2:0], 1'b0};      r.c = a[DATA_W-1]; end
      OP_SHR: begin r.lo = {1'b0, a[DATA_W-1:1]};      r.c = a[0];        end
      OP_ROL: begin r.lo = {a[DATA_W-2:0], a[DATA_W-1]}; r.c = a[DATA_W-1]; end
      OP_ROR: begin r.lo = {a[0], a[DATA_W-1:1]};      r.c = a[0];        end
      default: ;
    endcase
    r.z = (r.lo == '0);
    return r;
  endfunction
endpackage

// File: rtl/ofs_alu8_mul.sv
module ofs_alu8_mul
  import ofs_alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic           busy,
  output logic           fin,
  output logic [2*W-1:0] prod
);
  localparam int ITER = W;
  localparam int CW   = $clog2(ITER) + 1;

  logic           busy_q, fin_q, zero_op_q;
  logic [CW-1:0]  cnt_q;
  logic [2*W-1:0] acc_q, mcand_q;
  logic [W-1:0]   mplier_q;

  // named internal events
  logic step_add, last_step;
  assign step_add  = busy_q && mplier_q[0];
  assign last_step = busy_q && (cnt_q == CW'(ITER-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      fin_q     <= 1'b0;
      zero_op_q <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      mcand_q   <= '0;
      mplier_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        busy_q    <= 1'b1;
        cnt_q     <= '0;
        acc_q     <= '0;
        mcand_q   <= {{W{1'b0}}, mcand_in};
        mplier_q  <= mplier_in;
        zero_op_q <= (mcand_in == '0) || (mplier_in == '0);
      end else if (busy_q) begin
        if (step_add) acc_q <= acc_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q + CW'(1);
        if (last_step) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
  assign prod = acc_q;

  // R6: a zero factor must give a zero product
  p_mul_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q && zero_op_q |-> prod == '0);

  // R10: once finished the iteration engine is idle
  p_mul_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> !busy_q && fin_q);
endmodule

// File: rtl/ofs_alu8_div.sv
module ofs_alu8_div
  import ofs_alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num_hi,
  input  logic [W-1:0] num_lo,
  input  logic [W-1:0] dvs_in,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out,
  output logic         bad_div
);
  localparam int ITER = W;
  localparam int CW   = $clog2(ITER) + 1;

  logic          busy_q, fin_q, dz_q, ovf_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, low_q, dvs_q, keep_hi_q, keep_lo_q;

  // named internal events of the restoring step
  logic [W:0] trial, diff;
  logic       fits, last_step;
  assign trial     = {rem_q, low_q[W-1]};
  assign diff      = trial - {1'b0, dvs_q};
  assign fits      = trial >= {1'b0, dvs_q};
  assign last_step = busy_q && (cnt_q == CW'(ITER-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      fin_q     <= 1'b0;
      dz_q      <= 1'b0;
      ovf_q     <= 1'b0;
      cnt_q     <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      low_q     <= '0;
      dvs_q     <= '0;
      keep_hi_q <= '0;
      keep_lo_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        busy_q    <= 1'b1;
        cnt_q     <= '0;
        rem_q     <= num_hi;
        low_q     <= num_lo;
        quo_q     <= '0;
        dvs_q     <= dvs_in;
        keep_hi_q <= num_hi;
        keep_lo_q <= num_lo;
        dz_q      <= (dvs_in == '0);
        ovf_q     <= (dvs_in == '0) || (num_hi >= dvs_in);
      end else if (busy_q) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        low_q <= low_q << 1;
        cnt_q <= cnt_q + CW'(1);
        if (last_step) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign fin     = fin_q;
  assign quo_out = dz_q ? keep_hi_q : (ovf_q ? {W{1'b1}} : quo_q);
  assign rem_out = ovf_q ? keep_lo_q : rem_q;
  assign bad_div = ovf_q;

  // R7: a regular divide leaves a remainder below the divisor
  p_rem_below_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q && !ovf_q |-> rem_out < dvs_q);

  // R9: a zero divisor always flags the fault
  p_div_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q && (dvs_q == '0) |-> bad_div);
endmodule

// File: rtl/ofs_alu8.sv
module ofs_alu8
  import ofs_alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPC_W-1:0] in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [W-1:0]     in_c,
  output logic             in_ready,
  output logic             out_done,
  output logic [W-1:0]     out_hi,
  output logic [W-1:0]     out_lo,
  output logic             out_pair,
  output logic             flag_c,
  output logic             flag_z,
  output logic             flag_s
);
  logic           mul_busy, mul_fin, div_busy, div_fin, div_bad;
  logic [2*W-1:0] mul_prod;
  logic [W-1:0]   div_quo, div_rem;

  // named request events
  logic fire, fire_single, mul_start, div_start, md_fin;
  assign in_ready    = !(mul_busy || mul_fin || div_busy || div_fin);
  assign fire        = in_valid && in_ready && op_known(in_op);
  assign fire_single = fire && !op_multi(in_op);
  assign mul_start   = fire && (in_op == OP_MUL);
  assign div_start   = fire && (in_op == OP_DIV);
  assign md_fin      = mul_fin || div_fin;

  ofs_alu8_mul #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_start),
    .mcand_in(in_a), .mplier_in(in_b),
    .busy(mul_busy), .fin(mul_fin), .prod(mul_prod)
  );

  ofs_alu8_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num_hi(in_a), .num_lo(in_c), .dvs_in(in_b),
    .busy(div_busy), .fin(div_fin),
    .quo_out(div_quo), .rem_out(div_rem), .bad_div(div_bad)
  );

  alu_res_t one_res, mul_res, div_res, res_q;
  logic     done_q;

  assign one_res = single_op(in_op, in_a, in_b);

  always_comb begin
    mul_res      = '0;
    mul_res.hi   = mul_prod[2*W-1:W];
    mul_res.lo   = mul_prod[W-1:0];
    mul_res.pair = 1'b1;
    mul_res.z    = (mul_prod == '0);
    div_res      = '0;
    div_res.hi   = div_quo;
    div_res.lo   = div_rem;
    div_res.pair = 1'b1;
    div_res.c    = div_bad;
    div_res.z    = (div_quo == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fire_single) begin
        res_q  <= one_res;
        done_q <= 1'b1;
      end else if (mul_fin) begin
        res_q  <= mul_res;
        done_q <= 1'b1;
      end else if (div_fin) begin
        res_q  <= div_res;
        done_q <= 1'b1;
      end
    end
  end

  assign out_done = done_q;
  assign out_hi   = res_q.hi;
  assign out_lo   = res_q.lo;
  assign out_pair = res_q.pair;
  assign flag_c   = res_q.c;
  assign flag_z   = res_q.z;
  assign flag_s   = res_q.s;

  // R2: overflow and underflow are never reported together
  p_flag_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_c && flag_s));

  // R11: one-cycle operations complete on the next edge
  p_single_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire_single |=> out_done && !out_pair);

  // R10: a multi-cycle start closes the request port
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_start || div_start) |=> !in_ready);

  // R10: while busy and not finishing, results hold
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !md_fin |=> $stable({out_hi, out_lo, out_pair, flag_c, flag_z, flag_s}) && !out_done);
endmodule

// File: tb/tb_ofs_alu8.sv
module tb_ofs_alu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0, in_c = '0;
  logic       in_ready, out_done, out_pair, flag_c, flag_z, flag_s;
  logic [7:0] out_hi, out_lo;

  always #5 clk = ~clk;

  ofs_alu8 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_ready(in_ready),
    .out_done(out_done), .out_hi(out_hi), .out_lo(out_lo),
    .out_pair(out_pair), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  // reference model state (behavioural)
  int    e_hi, e_lo, e_pair, e_c, e_z, e_s, e_done, e_ready;
  string e_tag = "R12";
  int    p_hi, p_lo, p_pair, p_c, p_z, p_s;
  string p_tag;
  int    cd = 0;
  bit    took = 0;

  task automatic ref_calc(input int op, input int a, input int b, input int c,
                          output int hi, output int lo, output int pr,
                          output int cf, output int zf, output int sf,
                          output string tag);
    int v;
    hi = 0; lo = 0; pr = 0; cf = 0; sf = 0; tag = "R11";
    case (op)
      0:  begin v = a + b;       cf = v > 255; lo = v & 255; tag = "R1"; end
      1:  begin v = a - b;       sf = v < 0;   lo = v & 255; tag = "R1"; end
      2:  begin v = a + b - 128; cf = v > 255; sf = v < 0; lo = v & 255; tag = "R2"; end
      3:  begin v = a - b + 128; cf = v > 255; sf = v < 0; lo = v & 255; tag = "R2"; end
      4:  begin lo = a & b; tag = "R3"; end
      5:  begin lo = a | b; tag = "R3"; end
      6:  begin lo = a ^ b; tag = "R3"; end
      7:  begin lo = (a * 2) & 255; cf = a / 128; tag = "R4"; end
      8:  begin lo = a / 2; cf = a % 2; tag = "R4"; end
      9:  begin lo = ((a * 2) & 255) + a / 128; cf = a / 128; tag = "R4"; end
      10: begin lo = a / 2 + (a % 2) * 128; cf = a % 2; tag = "R4"; end
      11: begin v = a * b; hi = v / 256; lo = v % 256; pr = 1; tag = "R6"; end
      default: begin
        pr = 1;
        if (b == 0) begin hi = a; lo = c; cf = 1; tag = "R9"; end
        else if (a >= b) begin hi = 255; lo = c; cf = 1; tag = "R8"; end
        else begin v = a * 256 + c; hi = v / b; lo = v % b; tag = "R7"; end
      end
    endcase
    if (op == 11) zf = (hi == 0 && lo == 0);
    else if (op == 12) zf = (hi == 0);
    else zf = (lo == 0);
  endtask

  always @(posedge clk) begin
    int rdy0;
    took = 0;
    if (!rst_n) begin
      e_hi = 0; e_lo = 0; e_pair = 0; e_c = 0; e_z = 0; e_s = 0;
      e_done = 0; e_ready = 1; cd = 0; e_tag = "R12";
    end else begin
      rdy0   = e_ready;
      e_done = 0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          e_hi = p_hi; e_lo = p_lo; e_pair = p_pair;
          e_c = p_c; e_z = p_z; e_s = p_s; e_tag = p_tag;
          e_done = 1; e_ready = 1;
        end
      end
      if (in_valid && rdy0 != 0) begin
        took = 1;
        if (in_op < 11) begin
          ref_calc(int'(in_op), int'(in_a), int'(in_b), int'(in_c),
                   e_hi, e_lo, e_pair, e_c, e_z, e_s, e_tag);
          e_done = 1;
        end else if (in_op < 13) begin
          ref_calc(int'(in_op), int'(in_a), int'(in_b), int'(in_c),
                   p_hi, p_lo, p_pair, p_c, p_z, p_s, p_tag);
          cd = 9; e_ready = 0;
        end
      end else if (in_valid) begin
        e_tag = "R10";
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    // result bytes and carry/sign
    n_chk++;
    if (out_hi !== 8'(e_hi) || out_lo !== 8'(e_lo) || out_pair !== 1'(e_pair) ||
        flag_c !== 1'(e_c) || flag_s !== 1'(e_s)) begin
      n_bad++;
      $display("FAIL %s cyc=%0d act hi=%h lo=%h pr=%0d c=%0d s=%0d exp hi=%h lo=%h pr=%0d c=%0d s=%0d",
               e_tag, cyc, out_hi, out_lo, out_pair, flag_c, flag_s,
               8'(e_hi), 8'(e_lo), e_pair, e_c, e_s);
    end
    // zero flag, R5
    n_chk++;
    if (flag_z !== 1'(e_z)) begin
      n_bad++;
      $display("FAIL R5 cyc=%0d act z=%0d exp z=%0d", cyc, flag_z, e_z);
    end
    // handshake timing, R10 / R11
    n_chk++;
    if (out_done !== 1'(e_done) || in_ready !== 1'(e_ready)) begin
      n_bad++;
      $display("FAIL R10/R11 cyc=%0d act done=%0d ready=%0d exp done=%0d ready=%0d",
               cyc, out_done, in_ready, e_done, e_ready);
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic issue(input int op, input int a, input int b, input int c);
    @(negedge clk);
    in_valid = 1'b1;
    in_op = 4'(op); in_a = 8'(a); in_b = 8'(b); in_c = 8'(c);
    do begin
      @(posedge clk);
      #1;
    end while (!took);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R12: reset state observed over several cycles
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 add / subtract
    issue(0, 200, 100, 0); issue(0, 0, 0, 0); issue(1, 5, 10, 0); issue(1, 7, 7, 0);
    // R2 offset forms
    issue(2, 200, 100, 0); issue(2, 255, 255, 0); issue(2, 10, 20, 0);
    issue(3, 10, 200, 0); issue(3, 255, 0, 0); issue(3, 0, 128, 0);
    // R3 logic
    issue(4, 8'hF0, 8'h0F, 0); issue(5, 8'hA0, 8'h05, 0); issue(6, 8'h5A, 8'h5A, 0);
    // R4 shifts and rotates
    issue(7, 8'h81, 0, 0); issue(8, 8'h81, 0, 0); issue(9, 8'h81, 0, 0); issue(10, 8'h81, 0, 0);
    idle(2);
    // R6 multiply, R10 ignored request while busy
    issue(11, 255, 255, 0); issue(0, 1, 2, 0);
    issue(11, 0, 77, 0); issue(11, 16, 16, 0);
    // R7, R8, R9 divide
    issue(12, 8'h12, 8'h56, 8'h34); issue(12, 0, 5, 0); issue(12, 8'h80, 8'h10, 8'h33);
    issue(12, 9, 0, 8'h44); issue(12, 254, 255, 255);
    // R11 unused codes ignored
    issue(13, 1, 1, 1); issue(15, 3, 3, 3);
    idle(12);
    // mixed stream
    for (int i = 0; i < 400; i++) begin
      issue(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(0, 4)));
    end
    idle(15);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule